// File: doc/BRIEF.md
# Embedded CPU Boot and Control Register Bank

This block is the system register bank that sits between a host register bus and a small embedded processor. After reset it keeps the processor stopped and lets the host fill the processor's byte-wide program memory. The host does this through one data register backed by a hidden pointer. The pointer moves forward by one location on every access, reads and writes alike, and a write to the pointer register sets it to a new position. Once the host has checked the image by reading it back through the same data register, a single write to the control register starts the processor.

The bank also holds a read-only identity word built from parameters, a 32-bit mailbox that the host changes through separate set and clear offsets, and a clock-delay register in which only four bits are stored. The program memory sits inside the block. The processor reads it through its own synchronous port.

Register offsets on the 8-bit offset bus: 0x05 clock delay, 0x10 control, 0x11 memory pointer, 0x12 memory data, 0x15 mailbox value, 0x16 mailbox set, 0x17 mailbox clear, 0x18 identity. Every read is registered. `reg_rdata` is valid while `reg_rvalid` is high, which happens in the cycle after the `reg_rd` strobe.

Top module: `cpu_boot_regs`

## Requirements
- R1: After reset the control word reads 0x0000008C (hold, boot and host access set), so `cpu_reset`=1, `cpu_clk_en`=0, `cpu_boot_en`=1 and `cpu_clk_div`=0. The mailbox and clock delay read 0.
- R2: A read strobe produces `reg_rvalid`=1 and the read value on `reg_rdata` in the following cycle. Offsets not listed in the map, including mailbox set and clear, read 0.
- R3: The control word keeps bits 8 (clock divide), 7 (reset hold), 3 (boot enable), 2 (host memory access), 1 (clock enable) and 0 (soft reset). It reads back masked with 0x18F. One cycle after a write, `cpu_reset` equals bit 7, `cpu_clk_en` equals bit 1, `cpu_boot_en` equals bit 3 and `cpu_clk_div` equals bit 8.
- R4: A write to the pointer register loads the memory pointer from the low log2(depth) bits of the written data. Writing 0 selects location 0.
- R5: While bit 2 of the control word is set, a write to the data register stores bits 7:0 at the pointer and advances the pointer by one.
- R6: While bit 2 is set, a read of the data register returns the byte at the pointer in bits 7:0, with bits 31:8 zero, and advances the pointer by one.
- R7: While bit 2 is clear, data-register writes leave memory unchanged, data-register reads return 0, and neither moves the pointer.
- R8: The pointer wraps from location depth-1 to location 0.
- R9: The identity register reads {revision[3:0], device id[15:0], 12'h000} in bits 31:28, 27:12 and 11:0. Writes to it have no effect.
- R10: The clock-delay register stores only bits 5:4 and 1:0 (mask 0x33) and reads back exactly what was written under that mask.
- R11: A write to mailbox set ORs the data into the mailbox. A write to mailbox clear clears the bits written as 1. The mailbox value register reads the current contents.
- R12: The processor fetch port returns on `cpu_idata` the byte at `cpu_iaddr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| cpu_reset | output | 1 | Processor held in reset |
| cpu_clk_en | output | 1 | Processor clock enable |
| cpu_clk_div | output | 1 | Processor clock divide select |
| cpu_boot_en | output | 1 | Processor boots from program memory |
| cpu_iaddr | input | log2(SRAM_DEPTH) | Processor fetch address |
| cpu_idata | output | 8 | Processor fetch byte |

## Verification
Every register, and every memory byte the host reads, lands on `reg_rdata` in the cycle after the read strobe. The bench releases the strobe at the next falling edge and samples there, while `reg_rvalid` is high. Control outputs, pointer moves and mailbox updates take effect at the clock edge that captures the write, so the bench samples them at the falling edge that follows. The fetch port gets the same one-cycle treatment. Pointer behaviour is checked only through data-register reads, after a sequence of writes, blocked accesses and a wrap at the last location.

// File: rtl/cpu_boot_pkg.sv
package cpu_boot_pkg;
   localparam int unsigned BUS_AW = 8;
   localparam int unsigned BUS_DW = 32;

   localparam logic [BUS_AW-1:0] OFS_CLKDLY = 8'h05;
   localparam logic [BUS_AW-1:0] OFS_CTRL   = 8'h10;
   localparam logic [BUS_AW-1:0] OFS_PTR    = 8'h11;
   localparam logic [BUS_AW-1:0] OFS_DATA   = 8'h12;
   localparam logic [BUS_AW-1:0] OFS_MBOX   = 8'h15;
   localparam logic [BUS_AW-1:0] OFS_MSET   = 8'h16;
   localparam logic [BUS_AW-1:0] OFS_MCLR   = 8'h17;
   localparam logic [BUS_AW-1:0] OFS_IDENT  = 8'h18;

   localparam int unsigned CB_DIV   = 8;
   localparam int unsigned CB_HOLD  = 7;
   localparam int unsigned CB_BOOT  = 3;
   localparam int unsigned CB_EXT   = 2;
   localparam int unsigned CB_CLKEN = 1;
   localparam int unsigned CB_SRST  = 0;

   localparam int unsigned CTRL_W = 9;
   localparam logic [3:0] DLY_RESET = 4'h0;

   typedef struct packed {
      logic div;
      logic hold;
      logic boot;
      logic ext;
      logic clken;
      logic srst;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{div: 1'b0, hold: 1'b1, boot: 1'b1,
                                    ext: 1'b1, clken: 1'b0, srst: 1'b0};

   function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] w);
      ctrl_t c;
      c.div   = w[CB_DIV];
      c.hold  = w[CB_HOLD];
      c.boot  = w[CB_BOOT];
      c.ext   = w[CB_EXT];
      c.clken = w[CB_CLKEN];
      c.srst  = w[CB_SRST];
      return c;
   endfunction

   function automatic logic [BUS_DW-1:0] ctrl_pack(input ctrl_t c);
      logic [BUS_DW-1:0] w;
      w = '0;
      w[CB_DIV]   = c.div;
      w[CB_HOLD]  = c.hold;
      w[CB_BOOT]  = c.boot;
      w[CB_EXT]   = c.ext;
      w[CB_CLKEN] = c.clken;
      w[CB_SRST]  = c.srst;
      return w;
   endfunction
endpackage

// File: rtl/boot_ctrl_reg.sv
module boot_ctrl_reg
   import cpu_boot_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_dly,
   input  logic [CTRL_W-1:0] wbits,
   output ctrl_t             ctrl_q,
   output logic [3:0]        dly_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
         dly_q  <= DLY_RESET;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_unpack(wbits);
         if (wr_dly)  dly_q  <= {wbits[5:4], wbits[1:0]};
      end
   end
endmodule

// File: rtl/prog_sram_port.sv
module prog_sram_port #(
   parameter int unsigned DEPTH = 256,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_en,
   input  logic             ptr_ld,
   input  logic [PTR_W-1:0] ptr_ld_val,
   input  logic             data_wr,
   input  logic             data_rd,
   input  logic [7:0]       wbyte,
   output logic [7:0]       host_q,
   output logic [PTR_W-1:0] ptr_q,
   input  logic [PTR_W-1:0] cpu_iaddr,
   output logic [7:0]       cpu_idata
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
   localparam bit IS_POW2 = ((1 << PTR_W) == DEPTH);

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] ptr_inc;
   logic [PTR_W-1:0] ld_val;
   logic             do_wr;
   logic             do_rd;

   assign do_wr = data_wr && host_en;
   assign do_rd = data_rd && host_en;

   generate
      if (IS_POW2) begin : g_wrap_free
         assign ptr_inc = ptr_q + PTR_W'(1);
         assign ld_val  = ptr_ld_val;
      end else begin : g_wrap_cmp
         assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
         assign ld_val  = (ptr_ld_val > LAST) ? '0 : ptr_ld_val;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         host_q <= '0;
      end else begin
         if (ptr_ld)
            ptr_q <= ld_val;
         else if (do_wr || do_rd)
            ptr_q <= ptr_inc;
         if (do_rd)
            host_q <= mem[ptr_q];
         else if (data_rd)
            host_q <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[ptr_q] <= wbyte;
      cpu_idata <= mem[cpu_iaddr];
   end
endmodule

// File: rtl/mbox_reg.sv
module mbox_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] val_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         val_q <= '0;
      else if (set_we)
         val_q <= val_q | wdata;
      else if (clr_we)
         val_q <= val_q & ~wdata;
   end
endmodule

// File: rtl/cpu_boot_regs.sv
module cpu_boot_regs
   import cpu_boot_pkg::*;
#(
   parameter int unsigned SRAM_DEPTH = 256,
   parameter logic [15:0] DEV_ID     = 16'h5A3C,
   parameter logic [3:0]  DEV_REV    = 4'h2,
   localparam int unsigned PTR_W     = $clog2(SRAM_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              reg_rvalid,
   output logic              cpu_reset,
   output logic              cpu_clk_en,
   output logic              cpu_clk_div,
   output logic              cpu_boot_en,
   input  logic [PTR_W-1:0]  cpu_iaddr,
   output logic [7:0]        cpu_idata
);
   localparam logic [31:0] IDENT_WORD = {DEV_REV, DEV_ID, 12'h000};

   generate
      if (SRAM_DEPTH < 2) begin : g_bad_depth
         $error("SRAM_DEPTH must be at least 2");
      end
      if (BUS_DW != 32 || BUS_AW != 8) begin : g_bad_bus
         $error("register bus must be 8-bit offset, 32-bit data");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [3:0]       dly_q;
   logic [7:0]       host_q;
   logic [PTR_W-1:0] sram_ptr;
   logic [31:0]      mbox_val;
   logic             ext_en;
   logic [31:0]      rd_q;
   logic             rd_sram;

   logic wr_ctrl, wr_dly, wr_ptr, wr_data, rd_data, wr_mset, wr_mclr;
   assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
   assign wr_dly  = reg_wr && (reg_addr == OFS_CLKDLY);
   assign wr_ptr  = reg_wr && (reg_addr == OFS_PTR);
   assign wr_data = reg_wr && (reg_addr == OFS_DATA);
   assign rd_data = reg_rd && (reg_addr == OFS_DATA);
   assign wr_mset = reg_wr && (reg_addr == OFS_MSET);
   assign wr_mclr = reg_wr && (reg_addr == OFS_MCLR);

   boot_ctrl_reg u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (wr_ctrl),
      .wr_dly  (wr_dly),
      .wbits   (reg_wdata[CTRL_W-1:0]),
      .ctrl_q  (ctrl_q),
      .dly_q   (dly_q)
   );

   assign ext_en      = ctrl_q.ext;
   assign cpu_reset   = ctrl_q.hold;
   assign cpu_clk_en  = ctrl_q.clken;
   assign cpu_clk_div = ctrl_q.div;
   assign cpu_boot_en = ctrl_q.boot;

   prog_sram_port #(.DEPTH(SRAM_DEPTH)) u_sram (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_en    (ext_en),
      .ptr_ld     (wr_ptr),
      .ptr_ld_val (reg_wdata[PTR_W-1:0]),
      .data_wr    (wr_data),
      .data_rd    (rd_data),
      .wbyte      (reg_wdata[7:0]),
      .host_q     (host_q),
      .ptr_q      (sram_ptr),
      .cpu_iaddr  (cpu_iaddr),
      .cpu_idata  (cpu_idata)
   );

   mbox_reg #(.W(32)) u_mbox (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_mset),
      .clr_we (wr_mclr),
      .wdata  (reg_wdata),
      .val_q  (mbox_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rvalid <= 1'b0;
         rd_sram    <= 1'b0;
         rd_q       <= '0;
      end else begin
         reg_rvalid <= reg_rd;
         if (reg_rd) begin
            rd_sram <= (reg_addr == OFS_DATA);
            case (reg_addr)
               OFS_CLKDLY: rd_q <= {26'd0, dly_q[3:2], 2'b00, dly_q[1:0]};
               OFS_CTRL:   rd_q <= ctrl_pack(ctrl_q);
               OFS_PTR:    rd_q <= '0;
               OFS_MBOX:   rd_q <= mbox_val;
               OFS_IDENT:  rd_q <= IDENT_WORD;
               default:    rd_q <= '0;
            endcase
         end
      end
   end

   assign reg_rdata = rd_sram ? {24'd0, host_q} : rd_q;
endmodule

// File: rtl/cpu_boot_regs_chk.sv
module cpu_boot_regs_chk
   import cpu_boot_pkg::*;
#(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned PTR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic             reg_rd,
   input logic [7:0]       reg_addr,
   input logic [31:0]      reg_wdata,
   input logic [31:0]      reg_rdata,
   input logic             reg_rvalid,
   input logic             cpu_reset,
   input logic             cpu_clk_en,
   input logic             ext_en,
   input logic [PTR_W-1:0] sram_ptr,
   input logic [31:0]      mbox_val
);
   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rvalid);

   p_hold_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_CTRL) |=> cpu_reset == $past(reg_wdata[CB_HOLD]));

   p_clken_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_CTRL) |=> cpu_clk_en == $past(reg_wdata[CB_CLKEN]));

   p_ptr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_PTR && reg_wdata < DEPTH)
      |=> sram_ptr == $past(reg_wdata[PTR_W-1:0]));

   p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_wr || reg_rd) && reg_addr == OFS_DATA && ext_en)
      |=> sram_ptr == step($past(sram_ptr)));

   p_ptr_still_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_wr || reg_rd) && reg_addr == OFS_DATA && !ext_en) |=> $stable(sram_ptr));

   p_blocked_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == OFS_DATA && !ext_en) |=> reg_rdata == 32'd0);

   p_byte_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == OFS_DATA) |=> reg_rdata[31:8] == 24'd0);

   p_mbox_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_MSET) |=> mbox_val == ($past(mbox_val) | $past(reg_wdata)));

   p_mbox_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_MCLR) |=> mbox_val == ($past(mbox_val) & ~$past(reg_wdata)));
endmodule

bind cpu_boot_regs cpu_boot_regs_chk #(.DEPTH(SRAM_DEPTH), .PTR_W(PTR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .reg_rvalid (reg_rvalid),
   .cpu_reset  (cpu_reset),
   .cpu_clk_en (cpu_clk_en),
   .ext_en     (ext_en),
   .sram_ptr   (sram_ptr),
   .mbox_val   (mbox_val)
);

// File: tb/cpu_boot_regs_tb.sv
`timescale 1ns/1ps
module cpu_boot_regs_tb;
   localparam int unsigned DEPTH = 16;
   localparam int unsigned PW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_rd = 1'b0;
   logic [7:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          reg_rvalid;
   logic          cpu_reset, cpu_clk_en, cpu_clk_div, cpu_boot_en;
   logic [PW-1:0] cpu_iaddr = '0;
   logic [7:0]    cpu_idata;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   cpu_boot_regs #(.SRAM_DEPTH(DEPTH), .DEV_ID(16'h5A3C), .DEV_REV(4'h2)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_rvalid(reg_rvalid), .cpu_reset(cpu_reset), .cpu_clk_en(cpu_clk_en),
      .cpu_clk_div(cpu_clk_div), .cpu_boot_en(cpu_boot_en),
      .cpu_iaddr(cpu_iaddr), .cpu_idata(cpu_idata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      if (reg_rvalid !== 1'b1) chk("R2 rvalid", {31'd0, reg_rvalid}, 32'd1);
      d = reg_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R1 cpu_reset", {31'd0, cpu_reset}, 32'd1);
      chk("R1 cpu_clk_en", {31'd0, cpu_clk_en}, 32'd0);
      chk("R1 cpu_boot_en", {31'd0, cpu_boot_en}, 32'd1);
      chk("R1 cpu_clk_div", {31'd0, cpu_clk_div}, 32'd0);
      rd(8'h10, v); chk("R1 ctrl", v, 32'h8C);
      rd(8'h15, v); chk("R1 mbox", v, 32'h0);
      rd(8'h05, v); chk("R1 clkdly", v, 32'h0);
   endtask

   task automatic t_load_readback;
      logic [31:0] v;
      wr(8'h11, 32'h0);
      for (int i = 0; i < 6; i++) wr(8'h12, 32'hABCD_EF00 | (32'h31 + 32'(i * 7)));
      wr(8'h11, 32'h0);
      for (int i = 0; i < 6; i++) begin
         rd(8'h12, v);
         chk("R4 R5 R6 byte readback", v, 32'h31 + 32'(i * 7));
      end
   endtask

   task automatic t_no_access;
      logic [31:0] v;
      wr(8'h10, 32'h88);
      wr(8'h11, 32'h2);
      wr(8'h12, 32'hEE);
      rd(8'h12, v); chk("R7 blocked read zero", v, 32'h0);
      wr(8'h10, 32'h8C);
      rd(8'h12, v); chk("R7 pointer and memory unchanged", v, 32'h3F);
      rd(8'h12, v); chk("R6 pointer advanced after read", v, 32'h46);
   endtask

   task automatic t_wrap;
      logic [31:0] v;
      wr(8'h11, 32'(DEPTH - 1));
      wr(8'h12, 32'h5F);
      wr(8'h12, 32'h60);
      wr(8'h11, 32'(DEPTH - 1));
      rd(8'h12, v); chk("R8 last location", v, 32'h5F);
      rd(8'h12, v); chk("R8 wrapped to location 0", v, 32'h60);
   endtask

   task automatic t_fetch;
      @(negedge clk); cpu_iaddr = PW'(DEPTH - 1);
      @(negedge clk); chk("R12 fetch last", {24'd0, cpu_idata}, 32'h5F);
      cpu_iaddr = PW'(1);
      @(negedge clk); chk("R12 fetch loc1", {24'd0, cpu_idata}, 32'h38);
   endtask

   task automatic t_ctrl;
      logic [31:0] v;
      wr(8'h10, 32'h10B);
      chk("R3 cpu_reset released", {31'd0, cpu_reset}, 32'd0);
      chk("R3 cpu_clk_en", {31'd0, cpu_clk_en}, 32'd1);
      chk("R3 cpu_clk_div", {31'd0, cpu_clk_div}, 32'd1);
      chk("R3 cpu_boot_en", {31'd0, cpu_boot_en}, 32'd1);
      rd(8'h10, v); chk("R3 start readback", v, 32'h10B);
      wr(8'h10, 32'hFFFF_FFFF);
      rd(8'h10, v); chk("R3 masked readback", v, 32'h18F);
      wr(8'h10, 32'h8C);
      chk("R3 hold reasserted", {31'd0, cpu_reset}, 32'd1);
   endtask

   task automatic t_ident;
      logic [31:0] v;
      rd(8'h18, v); chk("R9 identity", v, 32'h25A3_C000);
      wr(8'h18, 32'h0);
      rd(8'h18, v); chk("R9 identity after write", v, 32'h25A3_C000);
   endtask

   task automatic t_clkdly;
      logic [31:0] v;
      wr(8'h05, 32'hFFFF_FFFF);
      rd(8'h05, v); chk("R10 mask", v, 32'h33);
      wr(8'h05, 32'h21);
      rd(8'h05, v); chk("R10 pattern 21", v, 32'h21);
      wr(8'h05, 32'h12);
      rd(8'h05, v); chk("R10 pattern 12", v, 32'h12);
   endtask

   task automatic t_mbox;
      logic [31:0] v;
      wr(8'h16, 32'hF0);
      rd(8'h15, v); chk("R11 set", v, 32'hF0);
      wr(8'h16, 32'h0F00_0001);
      rd(8'h15, v); chk("R11 set or", v, 32'h0F00_00F1);
      wr(8'h17, 32'h31);
      rd(8'h15, v); chk("R11 clear", v, 32'h0F00_00C0);
      rd(8'h16, v); chk("R2 set offset reads zero", v, 32'h0);
      rd(8'h00, v); chk("R2 unmapped reads zero", v, 32'h0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load_readback();
      t_no_access();
      t_wrap();
      t_fetch();
      t_ctrl();
      t_ident();
      t_clkdly();
      t_mbox();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule